// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Arbiter

This block sits beside a small 8-bit processor core and decides which of five hardware interrupt requests the core takes next. Each cycle it combines the request inputs with software mask bits, a global enable and two edge-capture latches. It then chooses the most urgent eligible source. Acceptance only happens on the cycle in which the core strobes the end of an instruction. One cycle later the block raises a single-cycle take pulse. The pulse carries a 16-bit restart vector, or a flag that tells the core to fetch the address from the external bus.

The sources do not all trigger the same way. The non-maskable source needs a rising edge and must still be high when it is taken. The second source is purely edge-captured. The remaining three are plain levels. Software loads the mask through a write strobe that has a separate load-qualify bit and a separate latch-clear bit. It reads the mask, the enable and the raw pending state back through one status bus.

Top module: `vint_ctrl`

## Requirements
- R1: After reset, `irq_take` and `irq_ext_fetch` are 0, `irq_vector` is 0x0000, the three mask bits are 1 (masked), the global enable is 0 and both edge latches are clear, so `mask_status` reads 7'h07.
- R2: The fixed priority from highest to lowest is `req_trap`, `req_r75`, `req_r65`, `req_r55`, `req_ext`. Acceptance happens only on a rising clock edge where `insn_end` is 1. `irq_take` is 1 in the cycle after that edge, and only in that cycle.
- R3: When the global enable is 0, no source except `req_trap` can be accepted. Mask bit 2 blocks `req_r75`, bit 1 blocks `req_r65` and bit 0 blocks `req_r55`; a value of 1 means masked. `req_ext` is gated only by the global enable.
- R4: The vectors are 0x0024 for `req_trap`, 0x003C for `req_r75`, 0x0034 for `req_r65` and 0x002C for `req_r55`.
- R5: Accepting `req_ext` raises `irq_ext_fetch` together with `irq_take`, and drives `irq_vector` to 0x0000.
- R6: A rising edge on `req_r75` sets a latch, and the request stays pending after the input falls. A level held high without a new edge does not raise the request again after acceptance.
- R7: `req_r65`, `req_r55` and `req_ext` are level-sensitive. A request that falls before the boundary edge is not accepted.
- R8: `req_trap` is accepted only if it rose after its last acceptance and is still high at the boundary edge. The mask and the global enable do not block it. Holding it high does not cause a second acceptance.
- R9: `mask_wr` together with `mask_ld` loads `mask_bits` into the mask. `mask_wr` without `mask_ld` leaves the mask unchanged. `mask_wr` together with `r75_clr` clears the `req_r75` latch.
- R10: Any acceptance clears the global enable. `gie_set` sets it and `gie_clr` clears it. Both acceptance and `gie_clr` take precedence over `gie_set`.
- R11: `mask_status` is {r75 latch, `req_r65`, `req_r55`, global enable, mask[2:0]}, with bit 6 as the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_trap | input | 1 | Non-maskable request, edge plus level |
| req_r75 | input | 1 | Edge-captured maskable request |
| req_r65 | input | 1 | Level maskable request |
| req_r55 | input | 1 | Level maskable request |
| req_ext | input | 1 | Level request with externally supplied vector |
| insn_end | input | 1 | Instruction-boundary strobe from the core |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| mask_wr | input | 1 | Set-mask write strobe |
| mask_ld | input | 1 | Qualify: load mask bits on this write |
| mask_bits | input | 3 | New mask {r75, r65, r55}, 1 = masked |
| r75_clr | input | 1 | Qualify: clear the r75 latch on this write |
| irq_take | output | 1 | One-cycle acknowledge pulse |
| irq_vector | output | 16 | Restart vector of the accepted source |
| irq_ext_fetch | output | 1 | Vector must be fetched from the bus |
| mask_status | output | 7 | Read-mask data |

## Verification
An edge latch stuck set shows as a repeated acknowledge. One that never sets shows as a missing acknowledge, and in either case bit 6 of `mask_status` is wrong in the cycle after the edge. A wrong global enable or mask bit shows on `mask_status` one cycle after the write. It shows again as a wrong or absent vector on the next boundary. The bench keeps a cycle model of the latches, mask and enable and compares every port after every edge. A corrupted bit is therefore caught at most one cycle after it is written.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int NSRC     = 5;
  localparam int VEC_W    = 16;
  localparam int VEC_STEP = 8;
  localparam int MASK_W   = 3;
  localparam int STAT_W   = MASK_W + 1 + MASK_W;

  // priority index: higher index wins
  localparam int SRC_EXT  = 0;
  localparam int SRC_R55  = 1;
  localparam int SRC_R65  = 2;
  localparam int SRC_R75  = 3;
  localparam int SRC_TRAP = 4;

  // restart vector = (doubled restart number) * step / 2
  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    int half;
    if (idx == SRC_EXT)       half = 0;
    else if (idx == SRC_TRAP) half = 9;
    else                      half = 2 * idx + 9;
    return VEC_W'(half * (VEC_STEP / 2));
  endfunction
endpackage

// File: rtl/vint_edge_cap.sv
module vint_edge_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q, lat_q, lat_n;

  always_comb begin
    if (clr) lat_n = 1'b0;
    else     lat_n = lat_q | (din & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= din;
      lat_q  <= lat_n;
    end
  end

  assign pend = lat_q;
endmodule

// File: rtl/vint_prio.sv
module vint_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] win,
  output logic         any
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_win
      if (i == N - 1) begin : g_top
        assign win[i] = elig[i];
      end else begin : g_rest
        assign win[i] = elig[i] & ~(|elig[N-1:i+1]);
      end
    end
  endgenerate

  assign any = |elig;
endmodule

// File: rtl/vint_mask_regs.sv
module vint_mask_regs #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          ld,
  input  logic [MW-1:0] bits,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic          accept,
  output logic [MW-1:0] mask,
  output logic          gie
);
  logic [MW-1:0] mask_q, mask_n;
  logic          gie_q, gie_n;
  logic          mask_en;

  assign mask_en = wr & ld;

  always_comb begin
    mask_n = mask_en ? bits : mask_q;
    if (accept || gie_clr) gie_n = 1'b0;
    else if (gie_set)      gie_n = 1'b1;
    else                   gie_n = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      gie_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      gie_q  <= gie_n;
    end
  end

  assign mask = mask_q;
  assign gie  = gie_q;
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
  import vint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_trap,
  input  logic              req_r75,
  input  logic              req_r65,
  input  logic              req_r55,
  input  logic              req_ext,
  input  logic              insn_end,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              mask_wr,
  input  logic              mask_ld,
  input  logic [MASK_W-1:0] mask_bits,
  input  logic              r75_clr,
  output logic              irq_take,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              irq_ext_fetch,
  output logic [STAT_W-1:0] mask_status
);
  logic [NSRC-1:0]   elig, win;
  logic              any, accept;
  logic              trap_lat, r75_lat;
  logic [MASK_W-1:0] mask;
  logic              gie;
  logic [VEC_W-1:0]  vec_n;
  logic              take_q, ext_q;
  logic [VEC_W-1:0]  vec_q;

  vint_edge_cap u_trap_cap (
    .clk (clk), .rst_n (rst_n), .din (req_trap),
    .clr (accept & win[SRC_TRAP]), .pend (trap_lat)
  );

  vint_edge_cap u_r75_cap (
    .clk (clk), .rst_n (rst_n), .din (req_r75),
    .clr ((mask_wr & r75_clr) | (accept & win[SRC_R75])), .pend (r75_lat)
  );

  vint_mask_regs #(.MW(MASK_W)) u_regs (
    .clk (clk), .rst_n (rst_n), .wr (mask_wr), .ld (mask_ld),
    .bits (mask_bits), .gie_set (gie_set), .gie_clr (gie_clr),
    .accept (accept), .mask (mask), .gie (gie)
  );

  always_comb begin
    elig           = '0;
    elig[SRC_TRAP] = trap_lat & req_trap;
    elig[SRC_R75]  = r75_lat & ~mask[2] & gie;
    elig[SRC_R65]  = req_r65 & ~mask[1] & gie;
    elig[SRC_R55]  = req_r55 & ~mask[0] & gie;
    elig[SRC_EXT]  = req_ext & gie;
  end

  vint_prio #(.N(NSRC)) u_prio (.elig (elig), .win (win), .any (any));

  assign accept = insn_end & any;

  always_comb begin
    vec_n = '0;
    for (int i = 0; i < NSRC; i++)
      if (win[i]) vec_n = vec_n | vec_of(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      ext_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= accept;
      ext_q  <= accept & win[SRC_EXT];
      if (accept) vec_q <= vec_n;
    end
  end

  assign irq_take      = take_q;
  assign irq_ext_fetch = ext_q;
  assign irq_vector    = vec_q;
  assign mask_status   = {r75_lat, req_r65, req_r55, gie, mask};
endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_trap,
  input logic        req_r75,
  input logic        req_r65,
  input logic        req_r55,
  input logic        req_ext,
  input logic        insn_end,
  input logic        gie_set,
  input logic        gie_clr,
  input logic        mask_wr,
  input logic        mask_ld,
  input logic [2:0]  mask_bits,
  input logic        r75_clr,
  input logic        irq_take,
  input logic [15:0] irq_vector,
  input logic        irq_ext_fetch,
  input logic [6:0]  mask_status
);
  assert_take_after_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(insn_end));

  assert_ext_with_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ext_fetch |-> (irq_take && irq_vector == 16'h0000));

  assert_fixed_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_ext_fetch) |-> (irq_vector == 16'h0024 || irq_vector == 16'h002C ||
                                      irq_vector == 16'h0034 || irq_vector == 16'h003C));

  assert_r75_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_vector == 16'h003C) |-> $past(!mask_status[2] && mask_status[3]));

  assert_trap_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_vector == 16'h0024) |-> $past(req_trap));

  assert_take_clears_gie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !mask_status[3]);
endmodule

bind vint_ctrl vint_ctrl_chk u_chk (.*);

// File: tb/vint_ctrl_test.sv
`timescale 1ns/1ps
module vint_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic req_trap, req_r75, req_r65, req_r55, req_ext, insn_end;
  logic gie_set, gie_clr, mask_wr, mask_ld, r75_clr;
  logic [2:0]  mask_bits;
  logic        irq_take, irq_ext_fetch;
  logic [15:0] irq_vector;
  logic [6:0]  mask_status;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  vint_ctrl uut (.*);

  // reference model, built from the requirements
  logic m_pt, m_lt, m_p7, m_l7, m_gie, m_take, m_ext;
  logic [2:0]  m_mask;
  logic [15:0] m_vec;

  always @(posedge clk or negedge rst_n) begin
    logic t, s7, s6, s5, e, acc;
    logic [15:0] v;
    if (!rst_n) begin
      m_pt = 0; m_lt = 0; m_p7 = 0; m_l7 = 0; m_gie = 0;
      m_take = 0; m_ext = 0; m_mask = 3'b111; m_vec = 0;
    end else begin
      t  = m_lt & req_trap;
      s7 = m_l7 & ~m_mask[2] & m_gie;
      s6 = req_r65 & ~m_mask[1] & m_gie;
      s5 = req_r55 & ~m_mask[0] & m_gie;
      e  = req_ext & m_gie;
      acc = insn_end & (t | s7 | s6 | s5 | e);
      if (t) v = 16'h0024; else if (s7) v = 16'h003C; else if (s6) v = 16'h0034;
      else if (s5) v = 16'h002C; else v = 16'h0000;
      m_take = acc;
      m_ext  = acc & e & ~t & ~s7 & ~s6 & ~s5;
      if (acc) m_vec = v;
      m_lt = (acc && t) ? 1'b0 : (m_lt | (req_trap & ~m_pt));
      m_l7 = ((mask_wr && r75_clr) || (acc && !t && s7)) ? 1'b0 : (m_l7 | (req_r75 & ~m_p7));
      if (mask_wr && mask_ld) m_mask = mask_bits;
      if (acc || gie_clr) m_gie = 0; else if (gie_set) m_gie = 1;
      m_pt = req_trap; m_p7 = req_r75;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    chk(tag, "take", {31'd0, irq_take}, {31'd0, m_take});
    chk(tag, "ext_fetch", {31'd0, irq_ext_fetch}, {31'd0, m_ext});
    chk(tag, "vector", {16'd0, irq_vector}, {16'd0, m_vec});
    chk("R11", "status", {25'd0, mask_status}, {25'd0, m_l7, req_r65, req_r55, m_gie, m_mask});
  endtask

  task automatic strobes_off();
    insn_end = 0; gie_set = 0; gie_clr = 0; mask_wr = 0; mask_ld = 0; r75_clr = 0;
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    cmp_model(tag);
    strobes_off();
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    req_trap = 0; req_r75 = 0; req_r65 = 0; req_r55 = 0; req_ext = 0;
    mask_bits = 3'b000;
    strobes_off();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "take", {31'd0, irq_take}, 0);
    chk("R1", "vector", {16'd0, irq_vector}, 0);
    chk("R1", "status", {25'd0, mask_status}, 32'h07);

    // R8 trap passes with everything masked and disabled
    req_trap = 1; tick("R8");
    insn_end = 1; tick("R8");
    chk("R8", "trap take", {31'd0, irq_take}, 1);
    chk("R4", "trap vector", {16'd0, irq_vector}, 32'h0024);
    insn_end = 1; tick("R8");
    chk("R8", "no retake on held level", {31'd0, irq_take}, 0);
    req_trap = 0;

    // R5 external vector
    gie_set = 1; tick("R10");
    req_ext = 1; insn_end = 1; tick("R5");
    chk("R5", "ext take", {31'd0, irq_take}, 1);
    chk("R5", "ext fetch", {31'd0, irq_ext_fetch}, 1);
    chk("R10", "gie cleared by accept", {31'd0, mask_status[3]}, 0);
    req_ext = 0;

    // R6 r75 edge latch
    mask_wr = 1; mask_ld = 1; mask_bits = 3'b000; gie_set = 1; tick("R9");
    req_r75 = 1; tick("R6");
    req_r75 = 0; tick("R6");
    chk("R6", "latch holds after drop", {31'd0, mask_status[6]}, 1);
    insn_end = 1; tick("R6");
    chk("R6", "r75 vector", {16'd0, irq_vector}, 32'h003C);

    // R9 write without load, then latch clear
    mask_wr = 1; mask_ld = 0; mask_bits = 3'b111; tick("R9");
    chk("R9", "mask kept", {29'd0, mask_status[2:0]}, 0);
    req_r75 = 1; tick("R9");
    req_r75 = 0; mask_wr = 1; r75_clr = 1; tick("R9");
    chk("R9", "latch cleared", {31'd0, mask_status[6]}, 0);

    // R10 clear beats set
    gie_set = 1; gie_clr = 1; tick("R10");
    chk("R10", "clr wins", {31'd0, mask_status[3]}, 0);

    // R7 level dropped before boundary
    gie_set = 1; tick("R7");
    req_r65 = 1; tick("R7");
    req_r65 = 0; insn_end = 1; tick("R7");
    chk("R7", "no take after drop", {31'd0, irq_take}, 0);

    // R3 masked r65 skipped
    mask_wr = 1; mask_ld = 1; mask_bits = 3'b010; tick("R3");
    req_r65 = 1; req_r55 = 1; insn_end = 1; tick("R3");
    chk("R3", "masked r65 skipped", {16'd0, irq_vector}, 32'h002C);

    // R2 priority among levels
    mask_wr = 1; mask_ld = 1; mask_bits = 3'b000; gie_set = 1; tick("R2");
    req_ext = 1; insn_end = 1; tick("R2");
    chk("R2", "r65 wins", {16'd0, irq_vector}, 32'h0034);
    req_r65 = 0; req_r55 = 0; req_ext = 0; tick("R2");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) req_trap = ~req_trap;
      if ($urandom_range(0, 5) == 0) req_r75  = ~req_r75;
      if ($urandom_range(0, 5) == 0) req_r65  = ~req_r65;
      if ($urandom_range(0, 5) == 0) req_r55  = ~req_r55;
      if ($urandom_range(0, 5) == 0) req_ext  = ~req_ext;
      insn_end = ($urandom_range(0, 2) == 0);
      gie_set  = ($urandom_range(0, 3) == 0);
      gie_clr  = ($urandom_range(0, 15) == 0);
      mask_wr  = ($urandom_range(0, 7) == 0);
      mask_ld  = $urandom_range(0, 1);
      r75_clr  = ($urandom_range(0, 3) == 0);
      mask_bits = 3'($urandom_range(0, 7));
      tick("R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule